// File: doc/BRIEF.md
# Flash Write-Buffer Program Sequencer

This block runs the buffered programming sequence of a flash memory that sits behind a 32-bit bus. The bus is built from two identical 16-bit devices, so each bus word is four bytes wide. The sequence opens with a buffer-program command. A byte then gives the word count minus one. Up to sixteen data words follow, and each carries its own address. A confirm code closes the sequence and commits the buffered words to the array.

The buffer is a sixteen-word window aligned by masking the word address. The low four bits of each data word's address pick its slot. A later word written to a slot replaces the earlier one.

During the commit, the block scans the slots in ascending order. It issues one array write request for each loaded slot, with a fixed number of cycles per word. An extended status byte reports whether the buffer can accept a new sequence. A status byte reports whether the state machine is ready, along with two sticky error flags. Every command other than the buffer-program sequence belongs to a separate command block, and this block ignores it.

Top module: `flash_wbuf_seq`

## Requirements
- R1: After reset, `xsr` reads 0x80 (bit 7 set means the buffer is available), `sts` reads 0x80 (bit 7 set means ready), and no array write is issued.
- R2: Outside a sequence, a bus write whose low data byte is 0xE8 starts a sequence, and `xsr` bit 7 reads 0 from the next cycle. Any other value written outside a sequence is ignored: `xsr` stays 0x80 and nothing is written.
- R3: The low data byte of the write after 0xE8 is n, and n+1 words follow. If n > 15, `sts` bit 4 (program error) is set, the sequence ends, and nothing is written.
- R4: The word address is the byte address shifted right by 2. The start address is the address of the 0xE8 write, and its word address with the low 4 bits cleared is the window. The slot is word address bits [3:0]. The commit writes each loaded slot once, in ascending slot order, to address window|slot. A slot written twice keeps the last data.
- R5: A data word whose word address bits [22:4] differ from the window's sets `sts` bit 4 and aborts the sequence, and nothing is written.
- R6: After the last data word, only a low byte of 0xD0 commits. Any other value sets `sts` bit 4 and aborts the sequence with nothing written.
- R7: If `blk_lock` bit k is set, where k is start word address bits [22:16], the 0xD0 write sets `sts` bit 1 (lock error) and nothing is written.
- R8: Bus writes made while the commit runs are ignored, including 0xE8. They change neither the data written nor the return to the available state.
- R9: `sts` bit 7 reads 0 while the commit runs. `xsr` bit 7 reads 0 from the 0xE8 write until the commit, or an abort, ends. Both read 1 afterwards.
- R10: `sts` bits 4 and 1 stay set until a cycle with `sts_clr` high clears them. Unrelated bus writes do not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | BYTE_AW (25) | Bus byte address |
| bus_wdata | input | 32 | Bus write data; commands use the low byte |
| blk_lock | input | 2^(BYTE_AW-2-BLK_WORDS_LOG2) (128) | Lock bit per block from the command block |
| sts_clr | input | 1 | Clears the sticky error bits |
| arr_we | output | 1 | Array write request, one cycle per word |
| arr_addr | output | BYTE_AW-2 (23) | Array word address |
| arr_wdata | output | 32 | Array write data |
| xsr | output | 8 | Extended status; bit 7 means buffer available |
| sts | output | 8 | Status; bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
The assertions assume that `bus_we` pulses for one cycle per bus write and that `bus_addr`, `bus_wdata` and `blk_lock` are steady while it is high. They also assume that `blk_lock` changes only while no sequence is open. The bench drives every write as a single-cycle pulse with an idle cycle after it, and it changes lock bits only while `xsr` bit 7 reads 1. Commands are sent as the same byte in both 16-bit halves, so the low byte always carries the command.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_LOAD,
    ST_CONF,
    ST_PROG
  } seq_st_t;

  localparam logic [7:0] CMD_BUF_PROG = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
endpackage

// File: rtl/fwb_buf.sv
module fwb_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [DW-1:0]    rd_q,
  output logic [DEPTH-1:0] valid
);
  logic [DW-1:0] mem [DEPTH];

  // plain synchronous write / registered read, block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
    rd_q <= mem[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_valid) valid <= '0;
    else if (wr_en)       valid[wr_slot] <= 1'b1;
  end

  // R4: a slot write marks that slot loaded on the next cycle
  p_slot_marked_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr_valid) |=> valid[$past(wr_slot)]);
endmodule

// File: rtl/fwb_commit.sv
module fwb_commit #(
  parameter int DEPTH    = 16,
  parameter int DW       = 32,
  parameter int WIN_W    = 19,
  parameter int PROG_CYC = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [WIN_W-1:0]       win,
  input  logic [DEPTH-1:0]       valid,
  input  logic [DW-1:0]          rd_q,
  output logic [IDX_W-1:0]       rd_slot,
  output logic                   active,
  output logic                   done,
  output logic                   arr_we,
  output logic [WIN_W+IDX_W-1:0] arr_addr,
  output logic [DW-1:0]          arr_wdata
);
  logic [IDX_W-1:0] slot;
  logic [CW-1:0]    cnt;
  logic             at_end, last, adv;

  assign at_end  = (cnt == CW'(PROG_CYC - 1));
  assign last    = (slot == IDX_W'(DEPTH - 1));
  assign adv     = !valid[slot] || at_end;
  assign rd_slot = slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      done      <= 1'b0;
      slot      <= '0;
      cnt       <= '0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      done   <= 1'b0;
      arr_we <= 1'b0;
      if (start) begin
        active <= 1'b1;
        slot   <= '0;
        cnt    <= '0;
      end else if (active) begin
        if (valid[slot]) cnt <= at_end ? '0 : cnt + CW'(1);
        if (valid[slot] && at_end) begin
          // rd_q holds this slot: it was read on an earlier cycle of this slot
          arr_we    <= 1'b1;
          arr_addr  <= {win, slot};
          arr_wdata <= rd_q;
        end
        if (adv) begin
          if (last) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            slot <= slot + IDX_W'(1);
          end
        end
      end
    end
  end

  // R8: array writes come only out of an active commit
  p_we_only_active_r8: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(active));
  // R9: completion is signalled exactly as the walker stops
  p_done_ends_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !active);
endmodule

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int WORD_AW  = 23,
  parameter int BLK_LOG2 = 16,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = IDX_W + 1,
  localparam int WIN_W   = WORD_AW - IDX_W,
  localparam int BLK_W   = WORD_AW - BLK_LOG2,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [WORD_AW-1:0] bus_waddr,
  input  logic [7:0]         bus_cmd,
  input  logic [NUM_BLK-1:0] blk_lock,
  input  logic               sts_clr,
  input  logic               commit_done,
  output logic               buf_clr,
  output logic               buf_we,
  output logic [IDX_W-1:0]   buf_slot,
  output logic               commit_start,
  output logic [WIN_W-1:0]   start_win,
  output logic               avail,
  output logic               ready,
  output logic               prog_err,
  output logic               lock_err
);
  seq_st_t          st, nxt;
  logic [CNT_W-1:0] need, loaded;
  logic             in_win, over_cnt, locked, pe_set, le_set;

  assign in_win   = (bus_waddr[WORD_AW-1:IDX_W] == start_win);
  assign over_cnt = (bus_cmd > 8'(DEPTH - 1));
  assign locked   = blk_lock[start_win[WIN_W-1 -: BLK_W]];
  assign buf_slot = bus_waddr[IDX_W-1:0];

  always_comb begin
    nxt          = st;
    buf_clr      = 1'b0;
    buf_we       = 1'b0;
    commit_start = 1'b0;
    pe_set       = 1'b0;
    le_set       = 1'b0;
    unique case (st)
      ST_IDLE: if (bus_we && bus_cmd == CMD_BUF_PROG) begin
        buf_clr = 1'b1;
        nxt     = ST_COUNT;
      end
      ST_COUNT: if (bus_we) begin
        if (over_cnt) begin
          pe_set = 1'b1;
          nxt    = ST_IDLE;
        end else begin
          nxt = ST_LOAD;
        end
      end
      ST_LOAD: if (bus_we) begin
        if (!in_win) begin
          pe_set = 1'b1;
          nxt    = ST_IDLE;
        end else begin
          buf_we = 1'b1;
          if (loaded + CNT_W'(1) == need) nxt = ST_CONF;
        end
      end
      ST_CONF: if (bus_we) begin
        if (bus_cmd != CMD_CONFIRM) begin
          pe_set = 1'b1;
          nxt    = ST_IDLE;
        end else if (locked) begin
          le_set = 1'b1;
          nxt    = ST_IDLE;
        end else begin
          commit_start = 1'b1;
          nxt          = ST_PROG;
        end
      end
      ST_PROG: if (commit_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      need      <= '0;
      loaded    <= '0;
      start_win <= '0;
      avail     <= 1'b1;
      ready     <= 1'b1;
      prog_err  <= 1'b0;
      lock_err  <= 1'b0;
    end else begin
      st    <= nxt;
      avail <= (nxt == ST_IDLE);
      ready <= (nxt != ST_PROG);
      if (buf_clr) start_win <= bus_waddr[WORD_AW-1:IDX_W];
      if (st == ST_COUNT && bus_we) begin
        need   <= {1'b0, bus_cmd[IDX_W-1:0]} + CNT_W'(1);
        loaded <= '0;
      end else if (buf_we) begin
        loaded <= loaded + CNT_W'(1);
      end
      if (pe_set)       prog_err <= 1'b1;
      else if (sts_clr) prog_err <= 1'b0;
      if (le_set)       lock_err <= 1'b1;
      else if (sts_clr) lock_err <= 1'b0;
    end
  end

  // R3: an oversize count byte aborts with the program error raised
  p_badcount_abort_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && bus_we && bus_cmd > 8'(DEPTH - 1))
      |=> (prog_err && st == ST_IDLE));
  // R5: a data word outside the window aborts with the program error raised
  p_window_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD && bus_we && bus_waddr[WORD_AW-1:IDX_W] != start_win)
      |=> (prog_err && st == ST_IDLE));
  // R3: never more words loaded than the count announced
  p_load_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (loaded < need));
  // R7: a lock error never coincides with a running commit
  p_lock_nostart_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_err) |-> (st == ST_IDLE));
endmodule

// File: rtl/flash_wbuf_seq.sv
module flash_wbuf_seq #(
  parameter int BYTE_AW        = 25,
  parameter int BLK_WORDS_LOG2 = 16,
  parameter int DEPTH          = 16,
  parameter int PROG_CYC       = 4
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         bus_we,
  input  logic [BYTE_AW-1:0]                           bus_addr,
  input  logic [31:0]                                  bus_wdata,
  input  logic [(1 << (BYTE_AW-2-BLK_WORDS_LOG2))-1:0] blk_lock,
  input  logic                                         sts_clr,
  output logic                                         arr_we,
  output logic [BYTE_AW-3:0]                           arr_addr,
  output logic [31:0]                                  arr_wdata,
  output logic [7:0]                                   xsr,
  output logic [7:0]                                   sts
);
  localparam int WORD_AW = BYTE_AW - 2;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int WIN_W   = WORD_AW - IDX_W;

  logic [WORD_AW-1:0] waddr;
  logic [1:0]         unused_byte_lane;
  logic               buf_clr, buf_we, commit_start, commit_done, commit_active;
  logic [IDX_W-1:0]   buf_slot, rd_slot;
  logic [WIN_W-1:0]   start_win;
  logic [DEPTH-1:0]   valid;
  logic [31:0]        rd_q;
  logic               avail, ready, prog_err, lock_err;

  assign waddr            = bus_addr[BYTE_AW-1:2];
  assign unused_byte_lane = bus_addr[1:0];

  fwb_ctrl #(.DEPTH(DEPTH), .WORD_AW(WORD_AW), .BLK_LOG2(BLK_WORDS_LOG2)) ctrl_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_waddr(waddr),
    .bus_cmd(bus_wdata[7:0]), .blk_lock(blk_lock), .sts_clr(sts_clr),
    .commit_done(commit_done), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_slot(buf_slot), .commit_start(commit_start), .start_win(start_win),
    .avail(avail), .ready(ready), .prog_err(prog_err), .lock_err(lock_err)
  );

  fwb_buf #(.DEPTH(DEPTH), .DW(32)) buf_i (
    .clk(clk), .rst(rst), .clr_valid(buf_clr), .wr_en(buf_we),
    .wr_slot(buf_slot), .wr_data(bus_wdata), .rd_slot(rd_slot),
    .rd_q(rd_q), .valid(valid)
  );

  fwb_commit #(.DEPTH(DEPTH), .DW(32), .WIN_W(WIN_W), .PROG_CYC(PROG_CYC)) commit_i (
    .clk(clk), .rst(rst), .start(commit_start), .win(start_win),
    .valid(valid), .rd_q(rd_q), .rd_slot(rd_slot), .active(commit_active),
    .done(commit_done), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  assign xsr = {avail, 7'b0};
  assign sts = {ready, 2'b00, prog_err, 2'b00, lock_err, 1'b0};

  // R4: every array write lands inside the window opened by the start command
  p_we_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_addr[WORD_AW-1:IDX_W] == start_win));
  // R9: the buffer never reports available while the commit runs
  p_busy_unavail_r9: assert property (@(posedge clk) disable iff (rst)
    commit_active |-> (!xsr[7] && !sts[7]));
endmodule

// File: tb/flash_wbuf_seq_tb_top.sv
module flash_wbuf_seq_tb_top;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [24:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [127:0] blk_lock = '0;
  logic        sts_clr = 1'b0;
  logic        arr_we;
  logic [22:0] arr_addr;
  logic [31:0] arr_wdata;
  logic [7:0]  xsr, sts;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [54:0] exp_q[$];
  logic [31:0] m_data[16];
  bit          m_val[16];

  always #(CLK_NS/2) clk = ~clk;

  flash_wbuf_seq dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .blk_lock(blk_lock), .sts_clr(sts_clr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .xsr(xsr), .sts(sts)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] ba(input logic [22:0] w);
    return {w, 2'b00};
  endfunction

  task automatic bus_wr(input logic [24:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic seq_open(input logic [22:0] w, input logic [7:0] n);
    bus_wr(ba(w), 32'h00E8_00E8);
    bus_wr(ba(w), {8'h00, n, 8'h00, n});
    for (int s = 0; s < 16; s++) m_val[s] = 1'b0;
  endtask

  task automatic seq_word(input logic [22:0] w, input int s, input logic [31:0] d);
    bus_wr(ba(w + 23'(s)), d);
    m_data[s] = d;
    m_val[s]  = 1'b1;
  endtask

  task automatic seq_commit(input logic [22:0] w);
    for (int s = 0; s < 16; s++)
      if (m_val[s]) exp_q.push_back({(w & 23'h7FFFF0) | 23'(s), m_data[s]});
    bus_wr(ba(w), 32'h00D0_00D0);
  endtask

  task automatic wait_avail(input string tag);
    int k = 0;
    do begin @(negedge clk); k++; end while (!xsr[7] && k < 500);
    chk(xsr[7], tag, 64'(xsr), 64'h80);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor: every array write must match the next expected item
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected array write", 64'({arr_addr, arr_wdata}), 64'h0);
      end else begin
        logic [54:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_wdata} == e, "R4 array write addr/data",
            64'({arr_addr, arr_wdata}), 64'(e));
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(xsr == 8'h80, "R1 xsr after reset", 64'(xsr), 64'h80);
    chk(sts == 8'h80, "R1 sts after reset", 64'(sts), 64'h80);
    chk(arr_we == 1'b0, "R1 no write after reset", 64'(arr_we), 64'h0);

    // R2 other commands ignored outside a sequence
    bus_wr(ba(23'h001230), 32'h0040_0040);
    @(negedge clk);
    chk(xsr == 8'h80, "R2 idle command ignored", 64'(xsr), 64'h80);

    // R2/R4/R8/R9 partial buffer with overwrite
    bus_wr(ba(23'h001230), 32'h00E8_00E8);
    @(negedge clk);
    chk(xsr == 8'h00, "R2 unavailable after start", 64'(xsr), 64'h00);
    bus_wr(ba(23'h001230), 32'h0003_0003);
    for (int s = 0; s < 16; s++) m_val[s] = 1'b0;
    seq_word(23'h001230, 5, 32'h1111_0005);
    seq_word(23'h001230, 2, 32'h2222_0002);
    seq_word(23'h001230, 5, 32'h3333_0005);
    @(negedge clk);
    chk(xsr == 8'h00, "R9 unavailable while loading", 64'(xsr), 64'h00);
    seq_word(23'h001230, 9, 32'h4444_0009);
    seq_commit(23'h001230);
    @(negedge clk);
    chk(sts == 8'h00, "R9 not ready while committing", 64'(sts), 64'h00);
    bus_wr(ba(23'h001230), 32'h00E8_00E8);   // R8 ignored during commit
    bus_wr(ba(23'h001231), 32'hDEAD_BEEF);
    wait_avail("R9 available after commit");
    chk(sts == 8'h80, "R8 ready and no error after commit", 64'(sts), 64'h80);
    chk(exp_q.size() == 0, "R4 all partial writes seen", 64'(exp_q.size()), 64'h0);

    // R4 full buffer, descending load order
    seq_open(23'h07FFF0, 8'h0F);
    for (int s = 15; s >= 0; s--) seq_word(23'h07FFF0, s, 32'hA500_0000 + 32'(s));
    seq_commit(23'h07FFF0);
    wait_avail("R9 available after full commit");
    chk(exp_q.size() == 0, "R4 all sixteen writes seen", 64'(exp_q.size()), 64'h0);

    // R3 oversize count
    bus_wr(ba(23'h001230), 32'h00E8_00E8);
    bus_wr(ba(23'h001230), 32'h0010_0010);
    @(negedge clk);
    chk(sts == 8'h90, "R3 count 17 gives program error", 64'(sts), 64'h90);
    chk(xsr == 8'h80, "R3 aborted sequence frees buffer", 64'(xsr), 64'h80);

    // R10 sticky error, then clear
    bus_wr(ba(23'h001230), 32'h0070_0070);
    repeat (4) @(negedge clk);
    chk(sts == 8'h90, "R10 error stays set", 64'(sts), 64'h90);
    @(posedge clk); #1 sts_clr = 1'b1;
    @(posedge clk); #1 sts_clr = 1'b0;
    @(negedge clk);
    chk(sts == 8'h80, "R10 error cleared", 64'(sts), 64'h80);

    // R5 address outside window
    seq_open(23'h001230, 8'h01);
    bus_wr(ba(23'h001240), 32'h5555_5555);
    @(negedge clk);
    chk(sts == 8'h90, "R5 window violation error", 64'(sts), 64'h90);
    chk(xsr == 8'h80, "R5 aborted sequence frees buffer", 64'(xsr), 64'h80);
    sts_clr = 1'b1; @(posedge clk); #1 sts_clr = 1'b0;

    // R6 wrong confirm code
    seq_open(23'h001230, 8'h00);
    bus_wr(ba(23'h001233), 32'h6666_6666);
    bus_wr(ba(23'h001230), 32'h00FF_00FF);
    repeat (80) @(negedge clk);
    chk(sts == 8'h90, "R6 bad confirm error", 64'(sts), 64'h90);
    chk(xsr == 8'h80, "R6 aborted sequence frees buffer", 64'(xsr), 64'h80);
    sts_clr = 1'b1; @(posedge clk); #1 sts_clr = 1'b0;

    // R7 locked block 5 (word address bits [22:16])
    blk_lock[5] = 1'b1;
    seq_open(23'h050040, 8'h00);
    bus_wr(ba(23'h050043), 32'h7777_7777);
    bus_wr(ba(23'h050040), 32'h00D0_00D0);
    repeat (80) @(negedge clk);
    chk(sts == 8'h82, "R7 lock error", 64'(sts), 64'h82);
    chk(xsr == 8'h80, "R7 buffer free after lock abort", 64'(xsr), 64'h80);
    blk_lock[5] = 1'b0;
    sts_clr = 1'b1; @(posedge clk); #1 sts_clr = 1'b0;
    @(negedge clk);
    chk(sts == 8'h80, "R10 lock error cleared", 64'(sts), 64'h80);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", 64'(exp_q.size()), 64'h0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule